// File: doc/BRIEF.md
# Epoch-Based Power Reassignment Controller

This controller sits between two supply rails of a stacked die assembly, a processor rail and a memory rail, and once per fixed epoch decides how much power a bidirectional on-die regulator of fixed rating should move from one rail to the other. At each epoch boundary it captures one power sample per rail into a short circular history. The history average of each rail, scaled by that rail's nominal budget, tells which side is busier. The history peak of the side that would give power up bounds how much can safely be lent.

The result is a signed transfer command, positive toward the processor, and the pair of effective budgets that follow from it. A pulse marks each new decision. Until both histories are full the controller moves nothing and reports the nominal budgets. A dead band around equal scaled load keeps the transfer direction from flipping when the two rails are about equally loaded.

Top module: `pwr_shift_ctrl`

## Requirements
- R1: `dec_o` is a one-cycle pulse that repeats every `EPOCH_CYCLES` clock cycles; every pulse comes with a new transfer and budget pair.
- R2: At each epoch boundary one sample of `cpu_pwr_i` and one of `mem_pwr_i` (unsigned milliwatts) are captured; a decision depends only on the last `DEPTH` (8) captured samples of each rail, and older samples stop affecting it.
- R3: Each rail's load is its history average (sum of the 8 samples shifted right by 3). The processor side wins when avg_cpu*MEM_NOM exceeds avg_mem*CPU_NOM plus the margin; the memory side wins when the reverse holds.
- R4: Headroom is the donor rail's nominal budget minus the largest sample in the donor's history, and is zero when that peak reaches or exceeds the nominal budget. The donor is the memory rail when the processor side wins and the processor rail otherwise.
- R5: The transfer magnitude never exceeds `XFER_MAX` (2000 mW); headroom above it is clipped to it.
- R6: `cpu_budget_o` + `mem_budget_o` always equals 5500 + 4500 mW; a full move toward the processor gives 7500/2500, a full move toward memory gives 3500/6500.
- R7: The margin is (avg_cpu*MEM_NOM + avg_mem*CPU_NOM) >> 4. When neither side wins by more than that margin, the previous transfer direction is kept (and the amount is re-sized from the current donor peak).
- R8: After reset and until 8 samples have been captured on each rail, `xfer_o` is 0 and the budgets are 5500 and 4500 mW.
- R9: `xfer_o` is two's complement; a positive value moves power to the processor (its budget rises by that amount), a negative value moves power to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_pwr_i | input | 16 | Processor rail power sample, mW |
| mem_pwr_i | input | 16 | Memory rail power sample, mW |
| dec_o | output | 1 | One-cycle pulse, new decision present |
| xfer_o | output | 16 | Signed transfer, mW, positive toward processor |
| cpu_budget_o | output | 16 | Effective processor budget, mW |
| mem_budget_o | output | 16 | Effective memory budget, mW |

## Verification
The assertions assume that each power sample is a plain unsigned milliwatt value that stays put for the whole epoch, so that the value captured at the boundary is the one meant for that epoch, and that the history depth is a power of two. The stimulus changes both samples only right after a decision pulse and holds them until the next capture. It walks through the fill period, a strong processor phase with clipped headroom, a near-balanced stretch inside the dead band, a memory phase in which an old processor peak has to age out of the window, and a long run of pseudo-random samples.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_CPU  = 2'd1,
    DIR_MEM  = 2'd2
  } dir_e;
endpackage

// File: rtl/pws_epoch_timer.sv
module pws_epoch_timer #(
  parameter int EPOCH_CYCLES = 1250,
  localparam int CW = (EPOCH_CYCLES > 2) ? $clog2(EPOCH_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam logic [CW-1:0] LAST = CW'(EPOCH_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R1
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/pws_rail_hist.sv
module pws_rail_hist #(
  parameter int PW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = PW + AW,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [PW-1:0] sample_i,
  output logic [PW-1:0] avg_o,
  output logic [PW-1:0] peak_o,
  output logic          full_o
);
  logic [PW-1:0] hist_q [DEPTH];
  logic [AW-1:0] wr_ptr_q;
  logic [SW-1:0] sum_q;
  logic [FW-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
      wr_ptr_q <= '0;
      sum_q    <= '0;
      fill_q   <= '0;
    end else if (tick_i) begin
      hist_q[wr_ptr_q] <= sample_i;
      // running sum: add newest, drop the entry it overwrites
      sum_q    <= sum_q + SW'(sample_i) - SW'(hist_q[wr_ptr_q]);
      wr_ptr_q <= wr_ptr_q + 1'b1;
      if (fill_q != FW'(DEPTH)) fill_q <= fill_q + 1'b1;
    end
  end

  always_comb begin
    peak_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (hist_q[i] > peak_o) peak_o = hist_q[i];
  end

  assign avg_o  = PW'(sum_q >> AW);
  assign full_o = (fill_q == FW'(DEPTH));

  // R3
  avg_le_peak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_o <= peak_o);
  // R2
  fill_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(fill_q));
endmodule

// File: rtl/pws_decide.sv
module pws_decide
  import pws_pkg::*;
#(
  parameter int PW       = 16,
  parameter int CPU_NOM  = 5500,
  parameter int MEM_NOM  = 4500,
  parameter int XFER_MAX = 2000,
  parameter int HYST_SH  = 4,
  localparam int SCW     = 2 * PW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic                 full_i,
  input  logic [PW-1:0]        cpu_avg_i,
  input  logic [PW-1:0]        mem_avg_i,
  input  logic [PW-1:0]        cpu_peak_i,
  input  logic [PW-1:0]        mem_peak_i,
  output logic                 dec_o,
  output logic signed [PW-1:0] xfer_o,
  output logic [PW-1:0]        cpu_bud_o,
  output logic [PW-1:0]        mem_bud_o
);
  localparam logic [PW-1:0]        CPU_N = PW'(CPU_NOM);
  localparam logic [PW-1:0]        MEM_N = PW'(MEM_NOM);
  localparam logic [PW-1:0]        XF    = PW'(XFER_MAX);
  localparam logic signed [PW-1:0] XF_S  = PW'(XFER_MAX);

  logic [SCW-1:0] cpu_sc, mem_sc, margin;
  logic           cpu_win, mem_win;
  dir_e           dir_q, dir_nx;
  logic [PW-1:0]  donor_peak, donor_nom, raw, head;
  logic signed [PW-1:0] xfer_nx;
  logic [PW-1:0]  cpu_bud_nx, mem_bud_nx;

  logic                 dec_q;
  logic signed [PW-1:0] xfer_q;
  logic [PW-1:0]        cpu_bud_q, mem_bud_q;

  // load normalised to each rail's own nominal budget
  assign cpu_sc  = SCW'(cpu_avg_i) * SCW'(MEM_N);
  assign mem_sc  = SCW'(mem_avg_i) * SCW'(CPU_N);
  assign margin  = (cpu_sc + mem_sc) >> HYST_SH;
  assign cpu_win = cpu_sc > (mem_sc + margin);
  assign mem_win = mem_sc > (cpu_sc + margin);

  always_comb begin
    if (!full_i)      dir_nx = DIR_NONE;
    else if (cpu_win) dir_nx = DIR_CPU;
    else if (mem_win) dir_nx = DIR_MEM;
    else              dir_nx = dir_q;

    donor_peak = (dir_nx == DIR_CPU) ? mem_peak_i : cpu_peak_i;
    donor_nom  = (dir_nx == DIR_CPU) ? MEM_N : CPU_N;
    raw        = (donor_peak >= donor_nom) ? '0 : donor_nom - donor_peak;
    if (dir_nx == DIR_NONE) head = '0;
    else if (raw > XF)      head = XF;
    else                    head = raw;

    if (dir_nx == DIR_MEM) begin
      xfer_nx    = -$signed(head);
      cpu_bud_nx = CPU_N - head;
      mem_bud_nx = MEM_N + head;
    end else begin
      xfer_nx    = $signed(head);
      cpu_bud_nx = CPU_N + head;
      mem_bud_nx = MEM_N - head;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q     <= DIR_NONE;
      dec_q     <= 1'b0;
      xfer_q    <= '0;
      cpu_bud_q <= CPU_N;
      mem_bud_q <= MEM_N;
    end else begin
      dec_q <= upd_i;
      if (upd_i) begin
        dir_q     <= dir_nx;
        xfer_q    <= xfer_nx;
        cpu_bud_q <= cpu_bud_nx;
        mem_bud_q <= mem_bud_nx;
      end
    end
  end

  assign dec_o     = dec_q;
  assign xfer_o    = xfer_q;
  assign cpu_bud_o = cpu_bud_q;
  assign mem_bud_o = mem_bud_q;

  // R5
  xfer_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_q <= XF_S) && (xfer_q >= -XF_S));
  // R6
  budget_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((PW+1)'(cpu_bud_q) + (PW+1)'(mem_bud_q)) == ((PW+1)'(CPU_N) + (PW+1)'(MEM_N)));
  // R8
  fill_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !full_i) |=> (xfer_q == 0) && (cpu_bud_q == CPU_N));
  // R7
  band_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && full_i && !cpu_win && !mem_win) |=> $stable(dir_q));
  // R9
  sign_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_q > 0) |-> (cpu_bud_q > CPU_N));
  // R1
  dec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_q |=> !dec_q);
endmodule

// File: rtl/pwr_shift_ctrl.sv
module pwr_shift_ctrl #(
  parameter int EPOCH_CYCLES = 1250,
  parameter int PW           = 16,
  parameter int DEPTH        = 8,
  parameter int CPU_NOM      = 5500,
  parameter int MEM_NOM      = 4500,
  parameter int XFER_MAX     = 2000,
  parameter int HYST_SH      = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] cpu_pwr_i,
  input  logic [15:0] mem_pwr_i,
  output logic        dec_o,
  output logic [15:0] xfer_o,
  output logic [15:0] cpu_budget_o,
  output logic [15:0] mem_budget_o
);
  logic          tick, upd_q;
  logic [PW-1:0] cpu_avg, mem_avg, cpu_peak, mem_peak;
  logic          cpu_full, mem_full;
  logic signed [PW-1:0] xfer;
  logic [PW-1:0] cpu_bud, mem_bud;

  pws_epoch_timer #(.EPOCH_CYCLES(EPOCH_CYCLES)) u_timer (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  pws_rail_hist #(.PW(PW), .DEPTH(DEPTH)) u_cpu_hist (
    .clk_i, .rst_ni, .tick_i(tick), .sample_i(PW'(cpu_pwr_i)),
    .avg_o(cpu_avg), .peak_o(cpu_peak), .full_o(cpu_full)
  );

  pws_rail_hist #(.PW(PW), .DEPTH(DEPTH)) u_mem_hist (
    .clk_i, .rst_ni, .tick_i(tick), .sample_i(PW'(mem_pwr_i)),
    .avg_o(mem_avg), .peak_o(mem_peak), .full_o(mem_full)
  );

  // decide one cycle after capture, once the history reflects the new sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= tick;
  end

  pws_decide #(
    .PW(PW), .CPU_NOM(CPU_NOM), .MEM_NOM(MEM_NOM),
    .XFER_MAX(XFER_MAX), .HYST_SH(HYST_SH)
  ) u_decide (
    .clk_i, .rst_ni,
    .upd_i(upd_q), .full_i(cpu_full && mem_full),
    .cpu_avg_i(cpu_avg), .mem_avg_i(mem_avg),
    .cpu_peak_i(cpu_peak), .mem_peak_i(mem_peak),
    .dec_o(dec_o), .xfer_o(xfer), .cpu_bud_o(cpu_bud), .mem_bud_o(mem_bud)
  );

  assign xfer_o       = 16'(xfer);
  assign cpu_budget_o = 16'(cpu_bud);
  assign mem_budget_o = 16'(mem_bud);

  // R2
  hist_lockstep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_full == mem_full);
endmodule

// File: tb/pwr_shift_ctrl_test.sv
`timescale 1ns/1ps
module pwr_shift_ctrl_test;
  localparam int EP = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_pwr = '0, mem_pwr = '0;
  logic        dec;
  logic [15:0] xfer, cpu_b, mem_b;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_shift_ctrl #(.EPOCH_CYCLES(EP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_pwr_i(cpu_pwr), .mem_pwr_i(mem_pwr),
    .dec_o(dec), .xfer_o(xfer), .cpu_budget_o(cpu_b), .mem_budget_o(mem_b)
  );

  typedef struct { int x; int cb; int mb; int tag; } exp_t;
  exp_t q[$];

  // reference model, built from the requirements
  int hc[8], hm[8];
  int ptr = 0, fill = 0, mdir = 0;

  function automatic string tag_name(int t);
    case (t)
      8: return "R8";
      7: return "R7 R9";
      4: return "R4 R2";
      5: return "R5 R9";
      default: return "R3 R2 R9";
    endcase
  endfunction

  function automatic void model_push(int c, int m);
    int sc, sm, pc, pm, raw, head, tag;
    longint cs, ms, mg;
    exp_t e;
    hc[ptr] = c; hm[ptr] = m; ptr = (ptr + 1) % 8;
    if (fill < 8) fill++;
    if (fill < 8) begin
      mdir = 0; e.x = 0; e.cb = 5500; e.mb = 4500; e.tag = 8;
      q.push_back(e);
      return;
    end
    sc = 0; sm = 0; pc = 0; pm = 0;
    for (int i = 0; i < 8; i++) begin
      sc += hc[i]; sm += hm[i];
      if (hc[i] > pc) pc = hc[i];
      if (hm[i] > pm) pm = hm[i];
    end
    cs = longint'(sc >> 3) * 4500;
    ms = longint'(sm >> 3) * 5500;
    mg = (cs + ms) >> 4;
    tag = 3;
    if (cs > ms + mg)      mdir = 1;
    else if (ms > cs + mg) mdir = 2;
    else                   tag = 7;
    if (mdir == 0) raw = 0;
    else if (mdir == 1) raw = (pm >= 4500) ? 0 : 4500 - pm;
    else                raw = (pc >= 5500) ? 0 : 5500 - pc;
    head = (raw > 2000) ? 2000 : raw;
    if (tag != 7) begin
      if (mdir != 0 && raw == 0) tag = 4;
      else if (raw > 2000)       tag = 5;
    end
    e.x  = (mdir == 2) ? -head : head;
    e.cb = 5500 + e.x;
    e.mb = 4500 - e.x;
    e.tag = tag;
    q.push_back(e);
  endfunction

  // monitor
  longint last_dec = -1;
  always @(negedge clk) begin
    if (rst_n && dec) begin
      exp_t e;
      if (last_dec >= 0) begin
        n_chk++;
        if (cyc - last_dec != EP) begin
          n_fail++;
          $display("FAIL R1 period actual=%0d expected=%0d", cyc - last_dec, EP);
        end
      end
      last_dec = cyc;
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R1 unexpected decision actual=1 expected=0");
      end else begin
        e = q.pop_front();
        if (int'($signed(xfer)) != e.x) begin
          n_fail++;
          $display("FAIL %s xfer actual=%0d expected=%0d", tag_name(e.tag), $signed(xfer), e.x);
        end
        n_chk++;
        if (int'(cpu_b) != e.cb || int'(mem_b) != e.mb) begin
          n_fail++;
          $display("FAIL R6 budgets actual=%0d/%0d expected=%0d/%0d", cpu_b, mem_b, e.cb, e.mb);
        end
      end
    end
  end

  task automatic run_epoch(int c, int m);
    cpu_pwr = 16'(c); mem_pwr = 16'(m);
    model_push(c, m);
    @(negedge clk);
    while (!dec) @(negedge clk);
  endtask

  task automatic drive_all();
    int unsigned seed = 32'h1234_5678;
    // R8 fill, then R5 clipped lend to processor
    for (int i = 0; i < 9; i++) run_epoch(6000, 2000);
    // R3 partial headroom after a memory spike
    run_epoch(6000, 3500);
    // R7 near balance: direction kept
    for (int i = 0; i < 8; i++) run_epoch(5500, 4500);
    run_epoch(5400, 4600);
    // R4 memory phase, old processor peak must age out (R2)
    for (int i = 0; i < 12; i++) run_epoch(1000, 6000);
    for (int i = 0; i < 3; i++) run_epoch(6200, 1000);
    for (int i = 0; i < 30; i++) begin
      int c, m;
      seed = seed * 32'd1103515245 + 32'd12345; c = int'((seed >> 8) % 8001);
      seed = seed * 32'd1103515245 + 32'd12345; m = int'((seed >> 8) % 8001);
      run_epoch(c, m);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    cpu_pwr = 16'd6000; mem_pwr = 16'd2000;
    repeat (3) @(negedge clk);
    // R8 reset state
    n_chk++;
    if (dec !== 1'b0 || xfer !== 16'd0 || cpu_b !== 16'd5500 || mem_b !== 16'd4500) begin
      n_fail++;
      $display("FAIL R8 reset actual=%0d/%0d/%0d/%0d expected=0/0/5500/4500", dec, xfer, cpu_b, mem_b);
    end
    rst_n = 1'b1;
    fork
      drive_all();
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 pending decisions actual=%0d expected=0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule